// File: doc/BRIEF.md
# I2C Multi-Master Transaction Sequencer

This block is a bit-level master engine for a two-wire bus that several masters share. It holds no register file. A host places a slave address, the transfer direction, the address width (7 or 10 bits), a data byte count and a per-field bit length on its inputs, then pulses a start request. The block lays down the START condition, the address bytes, the data fields and their acknowledge bits. It ends with a STOP condition, or with a repeated START where the 10-bit read format needs one. SCL and SDA are open-drain. The block only ever pulls a line low, through `scl_oe_o` and `sda_oe_o`, and it reads the resolved wire levels back on `scl_i` and `sda_i`.

The block watches the bus at all times. A START seen on the wires marks the bus busy, and a STOP marks it free, whichever master produced the condition. A start request is refused while the bus is busy. While the block shifts out its own address or data bits, it compares each bit it leaves high with the wire. If another master holds SDA low on such a bit, the block lets go of both lines at once and raises a sticky arbitration-lost flag. Each quarter of an SCL period lasts `PRE` clock cycles.

Top module: `i2c_mm_seq`

## Requirements
- R1: A 7-bit transfer begins with START (SDA falls while SCL is high), then address bits 6..0 MSB first, then the direction bit (0 write, 1 read), then one acknowledge clock in which the slave pulls SDA low.
- R2: Each data field is n bits, where n = `bits_i` and the value 0 means 8. A write sends `tx_data_i[n-1:0]` MSB first, sampled when the field begins. Every field is followed by an acknowledge clock. `byte_o` pulses once per field when that acknowledge is sampled.
- R3: A 10-bit write sends 1,1,1,1,0,a9,a8,0, then an acknowledge, then a7..a0, then an acknowledge, then the data fields.
- R4: A 10-bit read sends both address bytes as in R3. It then makes a repeated START (SCL low with SDA released, SCL high, then SDA falls), sends 1,1,1,1,0,a9,a8,1 with an acknowledge, and then receives data.
- R5: As receiver the block pulls SDA low in the acknowledge clock after every field but the last. On the last field it leaves SDA high (NACK) and then makes STOP. `rx_data_o` holds the n received bits right-justified, upper bits zero, while `byte_o` is high.
- R6: `busy_o` rises after a START is seen on the wires and falls after a STOP (SDA rises while SCL is high). A `start_i` pulse has no effect while `busy_o` is 1.
- R7: After the last write field, either ACK or NACK from the slave is followed by STOP, and `ack_o` reports that last acknowledge (1 = ACK). A NACK to an address byte or to an earlier field produces STOP at once, with `ack_o` = 0.
- R8: With `nbytes_i` = 0 the block sends only the address and then makes STOP.
- R9: SDA driven by the block changes while SCL is high only inside START, repeated START or STOP. STOP is SCL low with SDA low, then SCL high, then SDA released. `done_o` is a single-cycle pulse when the block returns to idle.
- R10: If SDA reads low while the block leaves high one of its own address or data bits, the block releases both lines at once and sets `arb_lost_o` with a `done_o` pulse, and makes no STOP. `arb_lost_o` clears when the next start is accepted.
- R11: After reset both line drivers are off and `busy_o`, `done_o`, `arb_lost_o` and `byte_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured in idle while bus free |
| addr_i | input | 10 | Slave address (bits 6..0 used in 7-bit mode) |
| ten_i | input | 1 | 1 selects 10-bit addressing |
| rd_i | input | 1 | 1 selects a read transfer |
| nbytes_i | input | NB_W | Number of data fields |
| bits_i | input | 3 | Bits per data field, 0 means 8 |
| tx_data_i | input | 8 | Write data for the field about to start |
| scl_i | input | 1 | Resolved SCL level |
| sda_i | input | 1 | Resolved SDA level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_o | output | 1 | Bus busy flag |
| done_o | output | 1 | One-cycle pulse at end of a transfer |
| ack_o | output | 1 | Last acknowledge seen from the slave |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |
| byte_o | output | 1 | Pulse per finished data field |
| rx_data_o | output | 8 | Received field, right-justified |

## Verification
The bench logs every SCL rising edge on the bus and compares it with the expected frame. A design that drops the repeated START in the 10-bit read, or that resends the first address byte with the wrong direction bit, therefore shows up as a bit mismatch. Short fields of 3 and 5 bits catch a bit counter that is reloaded wrongly or a received value that is not right-justified. The write cases end in a final NACK, in an address NACK and in an address-only transfer, which expose a design that keeps clocking or reports the wrong acknowledge. A bench-driven START checks that a start request is refused while the bus is taken. A slave that holds SDA low on a 1 bit checks that the block lets go without making a STOP and then clears its flag on the next transfer.

// File: rtl/i2c_mm_seq.sv
module i2c_mm_seq #(
  parameter int PRE  = 4,
  parameter int NB_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [9:0]      addr_i,
  input  logic            ten_i,
  input  logic            rd_i,
  input  logic [NB_W-1:0] nbytes_i,
  input  logic [2:0]      bits_i,
  input  logic [7:0]      tx_data_i,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            scl_oe_o,
  output logic            sda_oe_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            ack_o,
  output logic            arb_lost_o,
  output logic            byte_o,
  output logic [7:0]      rx_data_o
);
  localparam int CW = (PRE > 1) ? $clog2(PRE) : 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_t;
  typedef enum logic [1:0] {G_A1, G_A2, G_A1R, G_DAT} seg_t;

  st_t             st;
  seg_t            seg;
  logic [CW-1:0]   cnt;
  logic [1:0]      q;
  logic            ack_ph, rs, ten_l, rd_l, scl_q, sda_q;
  logic [3:0]      left;
  logic [7:0]      sh;
  logic [NB_W-1:0] nb;
  logic [9:0]      addr_l;
  logic [2:0]      bits_l;

  wire       tick      = (cnt == CW'(PRE - 1));
  wire [3:0] nbits     = {bits_l == 3'd0, bits_l};
  wire [7:0] txal      = tx_data_i << (4'd8 - nbits);
  wire [7:0] mask      = 8'hFF >> (4'd8 - nbits);
  wire       rx_mode   = (seg == G_DAT) && rd_l;
  wire [7:0] a1        = ten_l ? {5'b11110, addr_l[9:8], 1'b0} : {addr_l[6:0], rd_l};
  wire       own_one   = (st == S_BIT) && !ack_ph && !rx_mode && sh[7];
  wire       start_det = scl_q && scl_i && sda_q && !sda_i;
  wire       stop_det  = scl_q && scl_i && !sda_q && sda_i;

  assign scl_oe_o = ((st == S_BIT) && !q[1]) ||
                    ((st == S_START) && rs && (q == 2'd0)) ||
                    ((st == S_STOP) && (q == 2'd0));
  assign sda_oe_o = (st == S_START) ? q[1] :
                    (st == S_STOP)  ? !q[1] :
                    (st == S_BIT)   ? (ack_ph ? (rx_mode && nb != NB_W'(1)) : (!rx_mode && !sh[7])) :
                    1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; seg <= G_A1; cnt <= '0; q <= '0; ack_ph <= 1'b0; rs <= 1'b0;
      ten_l <= 1'b0; rd_l <= 1'b0; scl_q <= 1'b1; sda_q <= 1'b1; left <= '0; sh <= '0;
      nb <= '0; addr_l <= '0; bits_l <= '0; busy_o <= 1'b0; done_o <= 1'b0;
      ack_o <= 1'b0; arb_lost_o <= 1'b0; byte_o <= 1'b0; rx_data_o <= '0;
    end else begin
      scl_q  <= scl_i;
      sda_q  <= sda_i;
      done_o <= 1'b0;
      byte_o <= 1'b0;
      if (start_det)     busy_o <= 1'b1;
      else if (stop_det) busy_o <= 1'b0;
      if (st == S_IDLE) begin
        cnt <= '0; q <= '0;
      end else begin
        cnt <= tick ? '0 : cnt + CW'(1);
        if (tick) q <= q + 2'd1;
      end
      case (st)
        S_IDLE: if (start_i && !busy_o) begin
          st <= S_START; rs <= 1'b0; arb_lost_o <= 1'b0; ack_o <= 1'b0;
          addr_l <= addr_i; ten_l <= ten_i; rd_l <= rd_i; bits_l <= bits_i; nb <= nbytes_i;
        end
        S_START: if (tick && q == 2'd3) begin
          st <= S_BIT; ack_ph <= 1'b0; left <= 4'd8;
          seg <= rs ? G_A1R : G_A1;
          sh  <= rs ? {5'b11110, addr_l[9:8], 1'b1} : a1;
        end
        S_BIT: begin
          if (tick && q == 2'd2 && ack_ph) begin
            if (!rx_mode) ack_o <= !sda_i;
            if (seg == G_DAT) begin byte_o <= 1'b1; rx_data_o <= sh & mask; end
          end
          if (tick && q == 2'd3) begin
            if (!ack_ph) begin
              if (own_one && !sda_i) begin
                st <= S_IDLE; arb_lost_o <= 1'b1; done_o <= 1'b1;
              end else begin
                sh <= {sh[6:0], sda_i};
                left <= left - 4'd1;
                if (left == 4'd1) ack_ph <= 1'b1;
              end
            end else begin
              ack_ph <= 1'b0; left <= nbits; sh <= txal;
              if (!rx_mode && !ack_o) st <= S_STOP;
              else case (seg)
                G_A1: if (ten_l) begin
                  seg <= G_A2; sh <= addr_l[7:0]; left <= 4'd8;
                end else begin
                  seg <= G_DAT; if (nb == '0) st <= S_STOP;
                end
                G_A2: if (rd_l) begin
                  st <= S_START; rs <= 1'b1;
                end else begin
                  seg <= G_DAT; if (nb == '0) st <= S_STOP;
                end
                G_A1R: begin
                  seg <= G_DAT; if (nb == '0) st <= S_STOP;
                end
                default: begin
                  nb <= nb - NB_W'(1);
                  if (nb == NB_W'(1)) st <= S_STOP;
                end
              endcase
            end
          end
        end
        S_STOP: if (tick && q == 2'd3) begin
          st <= S_IDLE; done_o <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_IDLE && st == S_START) |-> $past(!busy_o && start_i));
  // R6
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy_o);
  // R9
  sda_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe_o && $past(!scl_oe_o) && !$stable(sda_oe_o)) |->
    ($past(st) == S_START || $past(st) == S_STOP));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost_o) |-> (st == S_IDLE && done_o && !scl_oe_o && !sda_oe_o));
endmodule

// File: tb/i2c_mm_seq_test.sv
module i2c_mm_seq_test;
  typedef struct packed {
    logic [15:0] tag;
    logic        ten, rd;
    logic [9:0]  addr;
    logic [3:0]  nb;
    logic [2:0]  bits;
    logic [7:0]  d;
    logic        lastnack, addrnack;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{"R1", 1'b0, 1'b0, 10'h02A, 4'd1, 3'd0, 8'h5B, 1'b0, 1'b0},
    '{"R2", 1'b0, 1'b0, 10'h051, 4'd3, 3'd3, 8'h06, 1'b0, 1'b0},
    '{"R3", 1'b1, 1'b0, 10'h2C5, 4'd2, 3'd0, 8'hA3, 1'b0, 1'b0},
    '{"R4", 1'b1, 1'b1, 10'h1F0, 4'd2, 3'd0, 8'h3C, 1'b0, 1'b0},
    '{"R5", 1'b0, 1'b1, 10'h013, 4'd3, 3'd5, 8'h11, 1'b0, 1'b0},
    '{"R7", 1'b0, 1'b0, 10'h06D, 4'd2, 3'd0, 8'hFE, 1'b1, 1'b0},
    '{"R8", 1'b0, 1'b0, 10'h035, 4'd0, 3'd0, 8'h00, 1'b0, 1'b0},
    '{"R7", 1'b0, 1'b0, 10'h04C, 4'd2, 3'd0, 8'h77, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [9:0] addr = '0;
  logic ten = 1'b0, rd = 1'b0;
  logic [3:0] nbytes = '0;
  logic [2:0] bits = '0;
  logic [7:0] tx_data, cur_d = '0, cur_mask = 8'hFF;
  logic scl_oe, sda_oe, busy, done, ack, arb, byte_s;
  logic [7:0] rx;
  logic slave_low = 1'b0, tb_sda_low = 1'b0, cur_rd = 1'b0, finished = 1'b0;
  wire scl_w = ~scl_oe;
  wire sda_w = ~(sda_oe | slave_low | tb_sda_low);
  int total = 0, fails = 0, pidx = 0, en = 0, bidx = 0;
  bit exp_b [128];
  bit slow [128];
  bit lg [128];

  assign tx_data = cur_d + 8'(bidx);

  always #4 clk = ~clk;

  i2c_mm_seq #(.PRE(2), .NB_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr), .ten_i(ten), .rd_i(rd),
    .nbytes_i(nbytes), .bits_i(bits), .tx_data_i(tx_data), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done), .ack_o(ack),
    .arb_lost_o(arb), .byte_o(byte_s), .rx_data_o(rx)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge scl_w) begin
    if (pidx < 128) lg[pidx] = sda_w;
    pidx = pidx + 1;
  end
  always @(negedge scl_w) slave_low = (pidx < 128) ? slow[pidx] : 1'b0;

  always @(negedge clk) if (rst_n && byte_s) begin
    if (cur_rd) chk(rx == ((cur_d + 8'(bidx)) & cur_mask), "R5", "received field", rx, (cur_d + 8'(bidx)) & cur_mask);
    bidx = bidx + 1;
  end

  task automatic put(input bit b, input bit s);
    exp_b[en] = b; slow[en] = s; en++;
  endtask

  task automatic put_byte(input logic [7:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) put(v[k], 1'b0);
  endtask

  task automatic build(input vec_t v);
    int n;
    logic [7:0] b;
    en = 0;
    for (int k = 0; k < 128; k++) begin exp_b[k] = 0; slow[k] = 0; end
    n = (v.bits == 3'd0) ? 8 : int'(v.bits);
    if (!v.ten) put_byte({v.addr[6:0], v.rd}, 8);
    else begin
      put_byte({5'b11110, v.addr[9:8], 1'b0}, 8); put(1'b0, 1'b1);
      put_byte(v.addr[7:0], 8);
    end
    if (v.addrnack) put(1'b1, 1'b0);
    else begin
      put(1'b0, 1'b1);
      if (v.ten && v.rd) begin
        put(1'b1, 1'b0);
        put_byte({5'b11110, v.addr[9:8], 1'b1}, 8); put(1'b0, 1'b1);
      end
      for (int i = 0; i < int'(v.nb); i++) begin
        b = v.d + 8'(i);
        if (!v.rd) begin
          put_byte(b, n);
          if (i == int'(v.nb) - 1 && v.lastnack) put(1'b1, 1'b0); else put(1'b0, 1'b1);
        end else begin
          for (int k = n - 1; k >= 0; k--) put(b[k], !b[k]);
          put(i == int'(v.nb) - 1, 1'b0);
        end
      end
    end
    put(1'b0, 1'b0);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input bit force_arb, output bit got);
    int n;
    n = (v.bits == 3'd0) ? 8 : int'(v.bits);
    addr = v.addr; ten = v.ten; rd = v.rd; nbytes = v.nb; bits = v.bits;
    cur_d = v.d; cur_rd = v.rd; cur_mask = 8'hFF >> (8 - n); bidx = 0;
    build(v);
    if (force_arb) slow[0] = 1'b1;
    pidx = 0; slave_low = 1'b0;
    pulse_start();
    got = 0;
    for (int c = 0; c < 5000 && !got; c++) begin
      @(negedge clk);
      if (done) got = 1;
    end
    @(negedge clk);
    chk(!done, "R9", "done pulse width", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    bit got;
    string tg;
    int bad, seen;
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R11", "drivers in reset", {scl_oe, sda_oe}, 0);
    chk(!busy && !done && !arb && !byte_s, "R11", "flags in reset", {busy, done, arb, byte_s}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !scl_oe && !sda_oe, "R11", "idle after reset", {busy, scl_oe, sda_oe}, 0);

    for (int i = 0; i < NV; i++) begin
      tg = $sformatf("%s", VECS[i].tag);
      run_vec(VECS[i], 1'b0, got);
      chk(got, tg, "done seen", got, 1);
      chk(pidx == en, tg, "SCL pulse count", pidx, en);
      bad = -1;
      for (int k = en - 1; k >= 0; k--) if (lg[k] !== exp_b[k]) bad = k;
      chk(bad < 0, tg, "first wrong bus bit", bad, -1);
      chk(ack == !(VECS[i].lastnack | VECS[i].addrnack), tg, "ack status", ack,
          !(VECS[i].lastnack | VECS[i].addrnack));
      chk(bidx == (VECS[i].addrnack ? 0 : int'(VECS[i].nb)), tg, "field strobes", bidx,
          VECS[i].addrnack ? 0 : int'(VECS[i].nb));
      repeat (4) @(negedge clk);
      chk(!busy && !arb && !scl_oe && !sda_oe, tg, "released and free", {busy, arb, scl_oe, sda_oe}, 0);
    end

    // R6: a foreign START holds the bus, start request is ignored
    tb_sda_low = 1'b1;
    repeat (6) @(negedge clk);
    chk(busy, "R6", "busy after foreign start", busy, 1);
    pidx = 0;
    pulse_start();
    seen = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (scl_oe || done) seen++;
    end
    chk(seen == 0 && pidx == 0, "R6", "activity while busy", seen, 0);
    tb_sda_low = 1'b0;
    repeat (6) @(negedge clk);
    chk(!busy, "R6", "free after foreign stop", busy, 0);

    // R10: slave holds SDA low on the first address bit, which is a 1
    run_vec('{"RA", 1'b0, 1'b0, 10'h040, 4'd1, 3'd0, 8'h00, 1'b0, 1'b0}, 1'b1, got);
    chk(got && arb, "R10", "arbitration flag", arb, 1);
    chk(!scl_oe && !sda_oe, "R10", "lines released", {scl_oe, sda_oe}, 0);
    chk(pidx == 1 && busy, "R10", "no STOP made", pidx, 1);
    slave_low = 1'b0;
    repeat (6) @(negedge clk);
    chk(!busy, "R6", "free after release", busy, 0);
    run_vec(VECS[0], 1'b0, got);
    chk(got && !arb && ack, "R10", "flag cleared by next start", arb, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule